// File: doc/BRIEF.md
# Pulse-Stream Weight Accumulator Synapse

This block forms the product of a pulse stream and a signed fixed-point weight without a multiplier. On every clock where the input pulse is high, the weight presented on that cycle is added into a signed accumulator. A frame-start strobe marks the boundary between frames. On that boundary the finished frame's sum is copied into an output register, a one-cycle valid strobe is raised, and the accumulator restarts.

The pulse count of a frame times the weight is the result. The weight can take any value its two's-complement width can hold, so there is no narrow range restriction. The accumulator is `WEIGHT_W + CNT_W` bits wide, so a frame of up to 2^`CNT_W` pulses at the most negative weight cannot wrap. A frame is at most 2^`CNT_W` cycles long.

A two-state controller governs the block:
- `SYN_IDLE` holds after reset until the first frame-start.
- `SYN_RUN` is active from then on.
- The transition `FIRST_START` (`SYN_IDLE` to `SYN_RUN`) is taken on the first frame-start.
- In `SYN_RUN`, every further frame-start takes the self-transition `FRAME_CLOSE`, which publishes a result.
- `SYN_RUN` keeps on any other cycle (`ACCUMULATE`).
- `SYN_IDLE` keeps until a frame-start (`WAIT_START`).

Top module: `pulse_synapse`

## Requirements
- R1: After reset, `product_vld` is 0 and `product_out` is 0.
- R2: Pulses that arrive before the first frame-start do not affect any result. The first frame-start closes no frame and raises no valid strobe.
- R3: For every weight in the signed `WEIGHT_W`-bit range (including the most negative), and every pulse count from 0 to 2^`CNT_W` within a frame, the published result equals pulse count times weight, as a signed two's-complement value of `WEIGHT_W + CNT_W` bits. It never wraps.
- R4: A pulse on the same cycle as a frame-start is counted in the frame that this strobe opens, not in the frame it closes.
- R5: `product_vld` is high for exactly the one cycle that follows each frame-start edge in `SYN_RUN`. `product_out` carries the new result in that same cycle.
- R6: Between valid strobes `product_out` keeps its last value, whatever the pulses and weight do.
- R7: Each pulse adds the weight presented on its own cycle, so a weight that changes within a frame gives the sum of the per-pulse weights.
- R8: Frame-starts on consecutive cycles form one-cycle frames. Each one publishes its own result, so `product_vld` stays high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe that closes the current frame and opens the next |
| pulse_in | input | 1 | Input pulse; high adds the weight this cycle |
| weight | input | WEIGHT_W | Signed two's-complement weight |
| product_out | output | WEIGHT_W+CNT_W | Signed sum of the last completed frame |
| product_vld | output | 1 | One-cycle strobe when `product_out` is updated |

## Verification
A frame-start sampled at a rising edge makes its result and strobe visible after that same edge. The pulse on that edge is already counted in the new frame. The result is therefore due one register stage after the strobe.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. The output it reads therefore reflects exactly the edge it has just driven.

Expected sums are accumulated arithmetically in the bench, pulse by pulse. Every frame-start is checked for the strobe and the value, and every cycle between strobes is checked for a low strobe and a held value.

// File: rtl/syn_pkg.sv
package syn_pkg;

    typedef enum logic [0:0] {
        SYN_IDLE = 1'b0,
        SYN_RUN  = 1'b1
    } syn_state_t;

endpackage

// File: rtl/syn_frame_fsm.sv
module syn_frame_fsm
    import syn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic acc_restart,
    output logic acc_enable,
    output logic publish
);

    syn_state_t state_q;
    syn_state_t state_d;

    // next-state: FIRST_START, WAIT_START, FRAME_CLOSE, ACCUMULATE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYN_IDLE: if (frame_start) state_d = SYN_RUN;
            SYN_RUN:  state_d = SYN_RUN;
            default:  state_d = SYN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYN_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        acc_restart = 1'b0;
        acc_enable  = 1'b0;
        publish     = 1'b0;
        unique case (state_q)
            SYN_IDLE: begin
                acc_restart = frame_start;
            end
            SYN_RUN: begin
                acc_restart = frame_start;
                acc_enable  = 1'b1;
                publish     = frame_start;
            end
            default: begin
                acc_restart = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/syn_addend.sv
module syn_addend #(
    parameter int WEIGHT_W = 12,
    parameter int ACC_W    = 20
) (
    input  logic                       pulse_in,
    input  logic signed [WEIGHT_W-1:0] weight,
    output logic signed [ACC_W-1:0]    addend
);

    localparam int EXT_W = ACC_W - WEIGHT_W;

    logic signed [ACC_W-1:0] weight_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign weight_ext = {{EXT_W{weight[WEIGHT_W-1]}}, weight};
        end else begin : g_same
            assign weight_ext = weight;
        end
    endgenerate

    assign addend = pulse_in ? weight_ext : '0;

endmodule

// File: rtl/syn_accum.sv
module syn_accum #(
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    enable,
    input  logic signed [ACC_W-1:0] addend,
    output logic signed [ACC_W-1:0] acc
);

    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (restart) acc <= addend;
        else if (enable)  acc <= acc + addend;
    end

endmodule

// File: rtl/syn_result.sv
module syn_result #(
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    publish,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] product_out,
    output logic                    product_vld
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product_out <= '0;
            product_vld <= 1'b0;
        end else begin
            product_vld <= publish;
            if (publish) product_out <= acc;
        end
    end

endmodule

// File: rtl/pulse_synapse.sv
module pulse_synapse #(
    parameter int WEIGHT_W = 12,
    parameter int CNT_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_start,
    input  logic                                pulse_in,
    input  logic signed [WEIGHT_W-1:0]          weight,
    output logic signed [WEIGHT_W+CNT_W-1:0]    product_out,
    output logic                                product_vld
);

    localparam int ACC_W = WEIGHT_W + CNT_W;

    logic                    acc_restart;
    logic                    acc_enable;
    logic                    publish;
    logic signed [ACC_W-1:0] addend;
    logic signed [ACC_W-1:0] acc;

    syn_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .acc_restart (acc_restart),
        .acc_enable  (acc_enable),
        .publish     (publish)
    );

    syn_addend #(.WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_addend (
        .pulse_in (pulse_in),
        .weight   (weight),
        .addend   (addend)
    );

    syn_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (acc_restart),
        .enable  (acc_enable),
        .addend  (addend),
        .acc     (acc)
    );

    syn_result #(.ACC_W(ACC_W)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .publish     (publish),
        .acc         (acc),
        .product_out (product_out),
        .product_vld (product_vld)
    );

endmodule

// File: rtl/syn_checker.sv
module syn_checker #(
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [ACC_W-1:0] product_out,
    input logic             product_vld
);

    logic opened_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           opened_q <= 1'b0;
        else if (frame_start) opened_q <= 1'b1;
    end

    // R2: the first frame-start publishes nothing
    a_r2_no_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !opened_q) |=> !product_vld);

    // R5: every later frame-start publishes
    a_r5_strobe_due: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && opened_q) |=> product_vld);

    // R5: no strobe without a preceding frame-start
    a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        product_vld |-> $past(frame_start));

    // R6: result holds while no strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !product_vld |-> $stable(product_out));

endmodule

bind pulse_synapse syn_checker #(.ACC_W(ACC_W)) u_syn_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .product_out (product_out),
    .product_vld (product_vld)
);

// File: tb/pulse_synapse_bench.sv
`timescale 1ns/1ps
module pulse_synapse_bench;

    localparam int WEIGHT_W = 4;
    localparam int CNT_W    = 3;
    localparam int ACC_W    = WEIGHT_W + CNT_W;
    localparam int FRAME_LEN = 1 << CNT_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                frame_start = 1'b0;
    logic                pulse_in = 1'b0;
    logic [WEIGHT_W-1:0] weight = '0;
    logic [ACC_W-1:0]    product_out;
    logic                product_vld;

    int checks = 0;
    int fails  = 0;
    int have_prev = 0;
    int prev_exp  = 0;
    int shown     = 0;

    always #2 clk = ~clk;

    pulse_synapse #(.WEIGHT_W(WEIGHT_W), .CNT_W(CNT_W)) u_pulse_synapse (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pulse_in    (pulse_in),
        .weight      (weight),
        .product_out (product_out),
        .product_vld (product_vld)
    );

    function automatic int out_val();
        return int'($signed(product_out));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // drive at the current falling edge, return at the next falling edge
    task automatic step(input bit fs, input bit p, input int w);
        frame_start = fs;
        pulse_in    = p;
        weight      = w[WEIGHT_W-1:0];
        @(negedge clk);
    endtask

    // checks after a frame-start step
    task automatic check_close(input string req);
        if (have_prev != 0) begin
            check(product_vld == 1'b1, req, int'(product_vld), 1);
            check(out_val() == prev_exp, req, out_val(), prev_exp);
            shown = prev_exp;
        end else begin
            check(product_vld == 1'b0, req, int'(product_vld), 0);
            check(out_val() == shown, req, out_val(), shown);
        end
    endtask

    // checks on a cycle with no frame-start
    task automatic check_quiet(input string req);
        check(product_vld == 1'b0, req, int'(product_vld), 0);
        check(out_val() == shown, req, out_val(), shown);
    endtask

    // frame of len cycles, pulses on the first npulse cycles, fixed weight
    task automatic frame(input int w, input int npulse, input int len, input string req);
        int acc = 0;
        for (int i = 0; i < len; i++) begin
            step(i == 0, i < npulse, w);
            if (i < npulse) acc += w;
            if (i == 0) check_close(req);
            else        check_quiet("R6");
        end
        have_prev = 1;
        prev_exp  = acc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(product_vld == 1'b0, "R1", int'(product_vld), 0);
        check(out_val() == 0, "R1", out_val(), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0);

        // R2: pulses before any frame-start are ignored
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 7);
            check_quiet("R2");
        end

        // R3, R4: exhaustive weights and counts, pulse on the frame-start cycle
        for (int w = -(1 << (WEIGHT_W-1)); w < (1 << (WEIGHT_W-1)); w++) begin
            for (int c = 0; c <= FRAME_LEN; c++) begin
                frame(w, c, FRAME_LEN, "R3");
            end
        end
        frame(0, 0, 3, "R3");

        // R4: only the frame-start pulse counts for the new frame
        frame(5, 1, 4, "R4");
        // R4: a pulse on the last cycle stays in the old frame
        step(1'b1, 1'b0, 0);
        check_close("R4");
        have_prev = 1;
        prev_exp  = 0;
        step(1'b0, 1'b0, 0);
        check_quiet("R6");
        step(1'b0, 1'b1, 3);
        check_quiet("R6");
        prev_exp = 3;
        step(1'b1, 1'b0, 0);
        check_close("R4");
        prev_exp = 0;

        // R7: weight changes within a frame
        step(1'b0, 1'b0, 0);
        check_quiet("R6");
        step(1'b1, 1'b1, 3);
        check_close("R7");
        step(1'b0, 1'b1, -2);
        check_quiet("R7");
        step(1'b0, 1'b0, 6);
        check_quiet("R7");
        step(1'b0, 1'b1, 7);
        check_quiet("R7");
        step(1'b0, 1'b1, -1);
        check_quiet("R7");
        prev_exp = 7;

        // R8: one-cycle frames back to back
        frame(-3, 1, 1, "R7");
        frame(0, 0, 1, "R8");
        frame(6, 1, 1, "R8");
        frame(-8, 1, 1, "R8");
        frame(1, 0, 1, "R8");
        step(1'b1, 1'b0, 0);
        check_close("R8");
        prev_exp = 0;

        // R6: held value under pulse activity with no frame-start
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, -5);
            check_quiet("R6");
        end
        report();
    end

endmodule